// File: doc/BRIEF.md
# Parallel Streaming Port with Framing

This block connects an on-chip word stream to an external programmable-logic device over a wide, clocked parallel path. In transmit direction, words queued in a small transmit FIFO are driven onto the output bus one per transfer slot, each marked by a write strobe. In receive direction, the input bus is sampled once per slot, each sample is marked by a read strobe, and the words are queued in a receive FIFO for the core to collect.

A programmable divider sets how often a transfer slot occurs. An external clock-enable input can hold the port off for any slot. Each word carries an address that counts up from zero and wraps at the configured width, and may be omitted. A frame output marks the first word of every frame, whose length in words is programmable. The clock output and the strobes can each be left out at build time. With the address and frame outputs ignored, the port serves as plain FIFO-backed parallel I/O at a chosen rate.

Top module: `gp_stream_port`

## Requirements
- R1: After reset every strobe, frame, clock, address and data output is 0, `tx_ready_o` is 1 and `rx_valid_o` is 0.
- R2: In transmit direction (`cfg_dir_i`=1), words leave in the order they were accepted. Each appears on `ext_dout_o` during a one-cycle `ext_wr_o` pulse.
- R3: A transfer slot occurs once every `cfg_div_i`+1 clock cycles. At most one word moves per slot, so back-to-back strobes are `cfg_div_i`+1 cycles apart while data is available.
- R4: When `ext_ce_i` is low at a slot, no word moves and no strobe pulses. Queued words remain and move once it is high again.
- R5: With the transmit FIFO empty, `ext_wr_o` stays low.
- R6: In receive direction (`cfg_dir_i`=0), `ext_din_i` is sampled at each slot edge and queued in order, and the cycle after the sample `ext_rd_o` pulses. No sample is taken while the receive FIFO (depth `FIFO_DEPTH`) is full.
- R7: `ext_frame_o` is high together with the strobe of the first word after reset and then of every (`cfg_frame_len_i`+1)-th word. It is low with the others.
- R8: `ext_addr_o` is 0 on the first word after reset and rises by one with each following word. It wraps to 0 after 2^`ADDR_W`-1. With `ADDR_W`=0 it stays 0.
- R9: `ext_clk_o` pulses high for one cycle per slot, whether or not a word moves. With `HAS_CLK`=0 it stays low, and with `HAS_STROBES`=0 both strobes stay low.
- R10: Only the strobe of the selected direction ever pulses, and `ext_wr_o` and `ext_rd_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_dir_i | input | 1 | 1 transmit, 0 receive |
| cfg_div_i | input | DIV_W | Slot period minus one |
| cfg_frame_len_i | input | FRAME_W | Words per frame minus one |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_data_i | input | DATA_W | Transmit word |
| tx_ready_o | output | 1 | Transmit FIFO has room |
| rx_valid_o | output | 1 | Receive word available |
| rx_data_o | output | DATA_W | Oldest received word |
| rx_ready_i | input | 1 | Pop receive word |
| ext_ce_i | input | 1 | External clock enable |
| ext_din_i | input | DATA_W | External input bus |
| ext_dout_o | output | DATA_W | External output bus |
| ext_addr_o | output | max(ADDR_W,1) | Word address |
| ext_wr_o | output | 1 | Write strobe |
| ext_rd_o | output | 1 | Read strobe |
| ext_frame_o | output | 1 | Frame start marker |
| ext_clk_o | output | 1 | Slot clock output |

## Verification
The hardest states to reach from the ports are a full receive FIFO while the external side keeps offering data, and an address counter crossing its wrap point in the middle of a frame. The bench models the external device as a source that advances only on each read strobe, and holds `rx_ready_i` low until the FIFO saturates, then drains it word by word. For the wrap, it streams more words than the address range holds, with a frame length that does not divide that range. The rate and hold checks preload the transmit FIFO with the clock enable low, so that the measured strobe spacing does not depend on when words were pushed.

// File: rtl/gps_pkg.sv
package gps_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } gps_dir_e;
endpackage

// File: rtl/gps_fifo.sv
module gps_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wp_q, rp_q;

  assign full_o  = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
  assign empty_o = (wp_q == rp_q);
  assign rdata_o = mem[rp_q[PW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q[PW-1:0]] <= wdata_i;
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/gps_tick_gen.sv
module gps_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= so a shrinking divisor never strands the counter above it
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gps_seq.sv
module gps_seq #(
  parameter int AW      = 4,
  parameter int FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [FRAME_W-1:0] len_i,
  output logic [AW-1:0]      addr_o,
  output logic               first_o
);
  logic [FRAME_W-1:0] fcnt_q;
  logic [AW-1:0]      acnt_q;

  assign addr_o  = acnt_q;
  assign first_o = (fcnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      acnt_q <= '0;
    end else if (step_i) begin
      acnt_q <= acnt_q + 1'b1;
      fcnt_q <= (fcnt_q >= len_i) ? '0 : fcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gp_stream_port.sv
module gp_stream_port #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int FIFO_DEPTH  = 4,
  parameter int DIV_W       = 8,
  parameter int FRAME_W     = 8,
  parameter bit HAS_CLK     = 1'b1,
  parameter bit HAS_STROBES = 1'b1,
  localparam int AW = (ADDR_W > 0) ? ADDR_W : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_dir_i,
  input  logic [DIV_W-1:0]   cfg_div_i,
  input  logic [FRAME_W-1:0] cfg_frame_len_i,
  input  logic               tx_valid_i,
  input  logic [DATA_W-1:0]  tx_data_i,
  output logic               tx_ready_o,
  output logic               rx_valid_o,
  output logic [DATA_W-1:0]  rx_data_o,
  input  logic               rx_ready_i,
  input  logic               ext_ce_i,
  input  logic [DATA_W-1:0]  ext_din_i,
  output logic [DATA_W-1:0]  ext_dout_o,
  output logic [AW-1:0]      ext_addr_o,
  output logic               ext_wr_o,
  output logic               ext_rd_o,
  output logic               ext_frame_o,
  output logic               ext_clk_o
);
  import gps_pkg::*;

  gps_dir_e          dir;
  logic              tick, xfer;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] tx_head;
  logic [AW-1:0]     seq_addr;
  logic              seq_first;

  logic [DATA_W-1:0] dout_q;
  logic [AW-1:0]     addr_q;
  logic              wr_q, rd_q, frame_q, clk_q;

  assign dir  = gps_dir_e'(cfg_dir_i);
  assign xfer = tick && ext_ce_i &&
                ((dir == DIR_TX) ? !tx_empty : !rx_full);

  gps_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk_i, .rst_ni, .div_i(cfg_div_i), .tick_o(tick)
  );

  gps_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_valid_i && !tx_full),
    .wdata_i(tx_data_i),
    .pop_i  (xfer && dir == DIR_TX),
    .rdata_o(tx_head),
    .full_o (tx_full),
    .empty_o(tx_empty)
  );

  gps_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (xfer && dir == DIR_RX),
    .wdata_i(ext_din_i),
    .pop_i  (rx_ready_i && !rx_empty),
    .rdata_o(rx_data_o),
    .full_o (rx_full),
    .empty_o(rx_empty)
  );

  gps_seq #(.AW(AW), .FRAME_W(FRAME_W)) i_seq (
    .clk_i, .rst_ni,
    .step_i (xfer),
    .len_i  (cfg_frame_len_i),
    .addr_o (seq_addr),
    .first_o(seq_first)
  );

  assign tx_ready_o = !tx_full;
  assign rx_valid_o = !rx_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      frame_q <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      wr_q    <= xfer && dir == DIR_TX;
      rd_q    <= xfer && dir == DIR_RX;
      frame_q <= xfer && seq_first;
      clk_q   <= tick;
      if (xfer)                 addr_q <= seq_addr;
      if (xfer && dir == DIR_TX) dout_q <= tx_head;
    end
  end

  assign ext_dout_o  = dout_q;
  assign ext_frame_o = frame_q;

  generate
    if (ADDR_W > 0) begin : g_addr
      assign ext_addr_o = addr_q;
      assert_addr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_q || rd_q) && $past(wr_q || rd_q) |->
          ext_addr_o == AW'($past(ext_addr_o) + 1'b1));
    end else begin : g_no_addr
      assign ext_addr_o = '0;
    end
    if (HAS_CLK) begin : g_clk
      assign ext_clk_o = clk_q;
    end else begin : g_no_clk
      assign ext_clk_o = 1'b0;
    end
    if (HAS_STROBES) begin : g_strb
      assign ext_wr_o = wr_q;
      assign ext_rd_o = rd_q;
    end else begin : g_no_strb
      assign ext_wr_o = 1'b0;
      assign ext_rd_o = 1'b0;
    end
  endgenerate

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_q && rd_q));
  assert_ce_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q || rd_q) |-> $past(ext_ce_i));
  assert_frame_on_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q |-> (wr_q || rd_q));
  assert_rate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q || rd_q) |-> $past(tick));
endmodule

// File: tb/test_gp_stream_port.sv
`timescale 1ns/1ps
module test_gp_stream_port;
  localparam int DW = 16;
  localparam int AWID = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dir = 1'b1;
  logic [7:0] cfg_div = '0;
  logic [7:0] cfg_len = '0;
  logic tx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_ready = 1'b0;
  logic [DW-1:0] rx_data;
  logic ce = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic [AWID-1:0] addr;
  logic wr, rd, frame, eclk;

  always #2.5 clk = ~clk;

  gp_stream_port i_gp_stream_port (
    .clk_i(clk), .rst_ni(rst_n), .cfg_dir_i(cfg_dir), .cfg_div_i(cfg_div),
    .cfg_frame_len_i(cfg_len), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .tx_ready_o(tx_ready), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_ready_i(rx_ready), .ext_ce_i(ce), .ext_din_i(din), .ext_dout_o(dout),
    .ext_addr_o(addr), .ext_wr_o(wr), .ext_rd_o(rd), .ext_frame_o(frame),
    .ext_clk_o(eclk)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  // monitor of strobed words
  int wr_n = 0, rd_n = 0, clk_n = 0;
  logic [DW-1:0] w_data [64];
  logic [AWID-1:0] w_addr [64];
  logic w_frame [64];
  int w_cyc [64];
  logic [AWID-1:0] r_addr [64];
  logic r_frame [64];
  logic [DW-1:0] src_next = 16'hA000;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (eclk) clk_n++;
    if (wr) begin
      if (wr_n < 64) begin
        w_data[wr_n] = dout; w_addr[wr_n] = addr;
        w_frame[wr_n] = frame; w_cyc[wr_n] = cyc;
      end
      wr_n++;
    end
    if (rd) begin
      if (rd_n < 64) begin r_addr[rd_n] = addr; r_frame[rd_n] = frame; end
      rd_n++;
      src_next = src_next + 1'b1;
      din = src_next;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic do_reset(input logic dir, input int div, input int len);
    @(negedge clk);
    rst_n = 1'b0; ce = 1'b0; tx_valid = 1'b0; rx_ready = 1'b0;
    cfg_dir = dir; cfg_div = 8'(div); cfg_len = 8'(len);
    src_next = 16'hA000; din = 16'hA000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wr_n = 0; rd_n = 0; clk_n = 0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b1, 0, 0);
    chk(!wr && !rd && !frame, "R1 strobes/frame", int'({wr, rd, frame}), 0);
    chk(dout == 0 && addr == 0, "R1 data/addr", int'(dout), 0);
    chk(tx_ready && !rx_valid, "R1 fifo flags", int'({tx_ready, rx_valid}), 2);
    chk(!eclk, "R1 clock out", int'(eclk), 0);
  endtask

  task automatic t_tx_basic();
    do_reset(1'b1, 0, 2);
    for (int i = 0; i < 4; i++) push(16'h1100 + 16'(i));
    repeat (3) @(negedge clk);
    chk(wr_n == 0, "R4 held while ce low", wr_n, 0);
    ce = 1'b1;
    for (int i = 4; i < 7; i++) push(16'h1100 + 16'(i));
    repeat (10) @(negedge clk);
    chk(wr_n == 7, "R2 word count", wr_n, 7);
    for (int i = 0; i < 7; i++) begin
      chk(w_data[i] == 16'h1100 + 16'(i), "R2 order", int'(w_data[i]), 'h1100 + i);
      chk(w_frame[i] == (i % 3 == 0), "R7 frame marker", int'(w_frame[i]), int'(i % 3 == 0));
      chk(w_addr[i] == 4'(i), "R8 address", int'(w_addr[i]), i);
    end
    repeat (5) @(negedge clk);
    chk(wr_n == 7, "R5 no strobe when empty", wr_n, 7);
    chk(rd_n == 0, "R10 no read strobe in transmit", rd_n, 0);
  endtask

  task automatic t_rate();
    do_reset(1'b1, 3, 0);
    for (int i = 0; i < 4; i++) push(16'h2200 + 16'(i));
    ce = 1'b1;
    repeat (24) @(negedge clk);
    chk(wr_n == 4, "R3 words at slow rate", wr_n, 4);
    for (int i = 1; i < 4; i++)
      chk(w_cyc[i] - w_cyc[i-1] == 4, "R3 strobe spacing", w_cyc[i] - w_cyc[i-1], 4);
  endtask

  task automatic t_ce_hold();
    do_reset(1'b1, 0, 0);
    ce = 1'b1;
    push(16'h3300);
    repeat (3) @(negedge clk);
    ce = 1'b0;
    for (int i = 1; i < 4; i++) push(16'h3300 + 16'(i));
    @(negedge clk);
    wr_n = 1;
    repeat (20) @(negedge clk);
    chk(wr_n == 1, "R4 no transfer while ce low", wr_n, 1);
    ce = 1'b1;
    repeat (8) @(negedge clk);
    chk(wr_n == 4, "R4 resumes after ce high", wr_n, 4);
    chk(w_data[3] == 16'h3303, "R4 queued word kept", int'(w_data[3]), 'h3303);
  endtask

  task automatic t_clk_out();
    do_reset(1'b1, 3, 0);
    ce = 1'b1;
    repeat (4) @(negedge clk);
    clk_n = 0;
    repeat (40) @(negedge clk);
    chk(clk_n == 10, "R9 clock pulses per slot", clk_n, 10);
    chk(wr_n == 0, "R5 empty fifo no strobe", wr_n, 0);
  endtask

  task automatic t_addr_wrap();
    do_reset(1'b1, 0, 4);
    ce = 1'b1;
    for (int i = 0; i < 20; i++) push(16'h4400 + 16'(i));
    repeat (10) @(negedge clk);
    chk(wr_n == 20, "R2 stream count", wr_n, 20);
    for (int i = 14; i < 20; i++) begin
      chk(w_addr[i] == 4'(i % 16), "R8 wrap", int'(w_addr[i]), i % 16);
      chk(w_frame[i] == (i % 5 == 0), "R7 frame across wrap", int'(w_frame[i]), int'(i % 5 == 0));
      chk(w_data[i] == 16'h4400 + 16'(i), "R2 stream order", int'(w_data[i]), 'h4400 + i);
    end
  endtask

  task automatic t_rx();
    do_reset(1'b0, 0, 1);
    ce = 1'b1;
    repeat (20) @(negedge clk);
    chk(rd_n == DEPTH, "R6 stops when rx fifo full", rd_n, DEPTH);
    chk(rx_valid, "R6 rx data available", int'(rx_valid), 1);
    chk(wr_n == 0, "R10 no write strobe in receive", wr_n, 0);
    for (int i = 0; i < 10; i++) begin
      while (!rx_valid) @(negedge clk);
      chk(rx_data == 16'hA000 + 16'(i), "R6 receive order", int'(rx_data), 'hA000 + i);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
    for (int i = 0; i < 6; i++) begin
      chk(r_frame[i] == (i % 2 == 0), "R7 frame in receive", int'(r_frame[i]), int'(i % 2 == 0));
      chk(r_addr[i] == 4'(i), "R8 address in receive", int'(r_addr[i]), i);
    end
  endtask

  initial begin
    t_reset();
    t_tx_basic();
    t_rate();
    t_ce_hold();
    t_clk_out();
    t_addr_wrap();
    t_rx();
    summary();
  end
endmodule